// File: doc/BRIEF.md
# Bus-Master DMA Channel Control and Status Register

This block is the per-channel control and status word of a storage-interface DMA engine. Software reaches it through a plain register port with a write strobe, write data and always-valid read data. The word holds the enable bit, the transfer direction and two spare capability bits. It also reports live status: engine active, bus error, completion, FIFO empty and an external watchdog flag.

From the enable bit the block derives single-cycle start and abort pulses for a DMA engine that sits outside it. It tracks whether a transfer is in flight. It also acts as a gate for task-file and PIO register accesses. While DMA is enabled, such an access gets an abort response and is not performed.

The completion bit has two personalities. While the channel is disabled it follows the device interrupt line. While the channel is enabled it becomes a sticky flag that software clears by writing 1. The error bit is always sticky and is cleared in the same way.

Top module: `bmdma_ctrl_reg`

## Requirements
- R1: Bit 0 is a read/write enable. A write that takes it from 0 to 1 while no transfer is active raises `eng_start` for exactly one cycle, and in that same cycle bit 16 (active) reads 1.
- R2: A write that clears bit 0 while bit 16 is 1 raises `eng_abort` for exactly one cycle, and bit 16 reads 0 from that cycle on.
- R3: Bit 3 is a read/write direction bit: 1 means device-to-memory and 0 means memory-to-device.
- R4: Bit 16 is read-only. It clears one cycle after `eng_done` is sampled high, and it is never 1 while bit 0 is 0.
- R5: Bit 17 (error) is set when `bus_err` is sampled high while bit 16 is 1. A write with data bit 17 set to 1 clears it; a write with that bit at 0 leaves it unchanged.
- R6: When a set event for bit 17 or bit 18 coincides with a write of 1 to that bit, the bit ends up at 1.
- R7: While bit 0 is 0, bit 18 reads the value `dev_irq` had at the previous clock edge, and writes to it have no effect.
- R8: While bit 0 is 1, bit 18 latches to 1 when `dev_irq` is high and either bit 3 is 0, or bit 3 is 1 with `fifo_empty` high and bit 16 at 0. It then holds until a write of 1 to bit 18.
- R9: Bit 19 reads the live `fifo_empty` input and bit 20 reads the live `wdog_flag` input.
- R10: Bits 22:21 are plain read/write storage. Bit 23 and the reserved bits 31:24, 15:4 and 2:1 always read 0, whatever is written.
- R11: A `tf_req` sampled while bit 0 is 1 yields `tf_abort` in the next cycle; one sampled while bit 0 is 0 yields `tf_pass` in the next cycle. The two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| dev_irq | input | 1 | Device interrupt line |
| eng_done | input | 1 | Engine reports that all data has moved |
| bus_err | input | 1 | Bus error seen while mastering |
| fifo_empty | input | 1 | Channel FIFO empty |
| wdog_flag | input | 1 | External watchdog flag |
| tf_req | input | 1 | Task-file or PIO access request |
| tf_abort | output | 1 | Access refused with an abort response |
| tf_pass | output | 1 | Access allowed to proceed |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_abort | output | 1 | One-cycle abort pulse to the engine |

## Verification
Two collisions in the same cycle matter most. The first is a hardware set event (`bus_err` during a transfer, or a qualifying `dev_irq`) arriving in the very cycle software writes 1 to clear the same flag. The bench drives both on one negedge and expects the flag to read 1 afterwards. The second is an `eng_done` arriving together with a write that re-enables or disables the channel. Here the bench checks that the active bit and the start or abort pulse follow the write, not the done. A seeded random phase with the channel disabled mixes arbitrary write data with random interrupt levels and compares the read word against a bench model.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int REG_W      = 32;
  localparam int BIT_EN     = 0;
  localparam int BIT_DIR    = 3;
  localparam int BIT_ACT    = 16;
  localparam int BIT_ERR    = 17;
  localparam int BIT_CMP    = 18;
  localparam int BIT_FEMPTY = 19;
  localparam int BIT_WDOG   = 20;
  localparam int BIT_CAP_LO = 21;
  localparam int CAP_W      = 2;
  localparam int BIT_SIMPLX = 23;

  typedef struct packed {
    logic             en;
    logic             dir;
    logic [CAP_W-1:0] cap;
    logic             act;
  } ctl_state_t;
endpackage

// File: rtl/bmdma_flag.sv
module bmdma_flag #(
  parameter bit MIRROR_IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic raw,
  input  logic set_ev,
  input  logic clr_wr,
  output logic flag
);
  generate
    if (MIRROR_IDLE) begin : g_mirror
      always_ff @(posedge clk) begin
        if (rst)         flag <= 1'b0;
        else if (!armed) flag <= raw;
        else if (set_ev) flag <= 1'b1;
        else if (clr_wr) flag <= 1'b0;
      end
    end else begin : g_sticky
      logic unused_in;
      assign unused_in = armed ^ raw;
      always_ff @(posedge clk) begin
        if (rst)         flag <= 1'b0;
        else if (set_ev) flag <= 1'b1;
        else if (clr_wr) flag <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/bmdma_ctl_core.sv
module bmdma_ctl_core
  import bmdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             w_en,
  input  logic             w_dir,
  input  logic [CAP_W-1:0] w_cap,
  input  logic             eng_done,
  output ctl_state_t       st,
  output logic             eng_start,
  output logic             eng_abort
);
  logic go_up, go_down;
  assign go_up   = wr &&  w_en && !st.en && !st.act;
  assign go_down = wr && !w_en &&  st.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= '0;
      eng_start <= 1'b0;
      eng_abort <= 1'b0;
    end else begin
      eng_start <= go_up;
      eng_abort <= go_down && st.act;
      if (wr) begin
        st.en  <= w_en;
        st.dir <= w_dir;
        st.cap <= w_cap;
      end
      if (go_down)       st.act <= 1'b0;
      else if (go_up)    st.act <= 1'b1;
      else if (eng_done) st.act <= 1'b0;
    end
  end
endmodule

// File: rtl/bmdma_tf_gate.sv
module bmdma_tf_gate (
  input  logic clk,
  input  logic rst,
  input  logic dma_en,
  input  logic req,
  output logic refuse,
  output logic allow
);
  always_ff @(posedge clk) begin
    if (rst) begin
      refuse <= 1'b0;
      allow  <= 1'b0;
    end else begin
      refuse <= req &&  dma_en;
      allow  <= req && !dma_en;
    end
  end
endmodule

// File: rtl/bmdma_ctrl_reg.sv
module bmdma_ctrl_reg
  import bmdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             dev_irq,
  input  logic             eng_done,
  input  logic             bus_err,
  input  logic             fifo_empty,
  input  logic             wdog_flag,
  input  logic             tf_req,
  output logic             tf_abort,
  output logic             tf_pass,
  output logic             eng_start,
  output logic             eng_abort
);
  ctl_state_t st;
  logic err_q, cmp_q, cmp_set;

  bmdma_ctl_core u_core (
    .clk(clk), .rst(rst), .wr(reg_wr),
    .w_en(reg_wdata[BIT_EN]), .w_dir(reg_wdata[BIT_DIR]),
    .w_cap(reg_wdata[BIT_CAP_LO +: CAP_W]),
    .eng_done(eng_done), .st(st),
    .eng_start(eng_start), .eng_abort(eng_abort)
  );

  bmdma_flag #(.MIRROR_IDLE(1'b0)) u_err (
    .clk(clk), .rst(rst), .armed(1'b1), .raw(1'b0),
    .set_ev(bus_err && st.act),
    .clr_wr(reg_wr && reg_wdata[BIT_ERR]),
    .flag(err_q)
  );

  assign cmp_set = dev_irq && (!st.dir || (fifo_empty && !st.act));

  bmdma_flag #(.MIRROR_IDLE(1'b1)) u_cmp (
    .clk(clk), .rst(rst), .armed(st.en), .raw(dev_irq),
    .set_ev(cmp_set),
    .clr_wr(reg_wr && reg_wdata[BIT_CMP]),
    .flag(cmp_q)
  );

  bmdma_tf_gate u_gate (
    .clk(clk), .rst(rst), .dma_en(st.en), .req(tf_req),
    .refuse(tf_abort), .allow(tf_pass)
  );

  always_comb begin
    reg_rdata                        = '0;
    reg_rdata[BIT_EN]                = st.en;
    reg_rdata[BIT_DIR]               = st.dir;
    reg_rdata[BIT_ACT]               = st.act;
    reg_rdata[BIT_ERR]               = err_q;
    reg_rdata[BIT_CMP]               = cmp_q;
    reg_rdata[BIT_FEMPTY]            = fifo_empty;
    reg_rdata[BIT_WDOG]              = wdog_flag;
    reg_rdata[BIT_CAP_LO +: CAP_W]   = st.cap;
    reg_rdata[BIT_SIMPLX]            = 1'b0;
  end
endmodule

// File: rtl/bmdma_ctrl_reg_chk.sv
module bmdma_ctrl_reg_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        bus_err,
  input logic        eng_done,
  input logic        tf_abort,
  input logic        tf_pass,
  input logic        eng_start,
  input logic        eng_abort
);
  a_r1_start_single: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);
  a_r1_start_active: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> reg_rdata[16] && reg_rdata[0]);
  a_r2_abort_single: assert property (@(posedge clk) disable iff (rst)
    eng_abort |=> !eng_abort);
  a_r2_abort_idle: assert property (@(posedge clk) disable iff (rst)
    eng_abort |-> !reg_rdata[16] && !reg_rdata[0]);
  a_r4_active_needs_en: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[16] |-> reg_rdata[0]);
  a_r4_done_clears: assert property (@(posedge clk) disable iff (rst)
    (eng_done && !reg_wr) |=> !reg_rdata[16]);
  a_r5_err_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_rdata[17]) |-> $past(bus_err));
  a_r6_err_set_wins: assert property (@(posedge clk) disable iff (rst)
    (bus_err && reg_rdata[16]) |=> reg_rdata[17]);
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[31:23] == 9'd0 && reg_rdata[15:4] == 12'd0 && reg_rdata[2:1] == 2'd0);
  a_r11_tf_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(tf_abort && tf_pass));
endmodule

bind bmdma_ctrl_reg bmdma_ctrl_reg_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .bus_err(bus_err), .eng_done(eng_done),
  .tf_abort(tf_abort), .tf_pass(tf_pass),
  .eng_start(eng_start), .eng_abort(eng_abort)
);

// File: tb/bmdma_ctrl_reg_bench.sv
`timescale 1ns/1ps
module bmdma_ctrl_reg_bench;
  logic clk = 1'b0;
  logic rst;
  logic reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic dev_irq, eng_done, bus_err, fifo_empty, wdog_flag, tf_req;
  logic tf_abort, tf_pass, eng_start, eng_abort;
  int   n_run = 0, n_fail = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  bmdma_ctrl_reg u_bmdma_ctrl_reg (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dev_irq(dev_irq), .eng_done(eng_done),
    .bus_err(bus_err), .fifo_empty(fifo_empty), .wdog_flag(wdog_flag),
    .tf_req(tf_req), .tf_abort(tf_abort), .tf_pass(tf_pass),
    .eng_start(eng_start), .eng_abort(eng_abort)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_reg(logic [31:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  function automatic logic [31:0] model_idle(logic [31:0] w, logic irq, logic fe, logic wd);
    logic [31:0] r = '0;
    r[3] = w[3]; r[22:21] = w[22:21];
    r[18] = irq; r[19] = fe; r[20] = wd;
    return r;
  endfunction

  initial begin
    #(20000 * 10);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seed = 32'h1234;
    void'($urandom(seed));
    rst = 1'b1; reg_wr = 0; reg_wdata = '0; dev_irq = 0; eng_done = 0;
    bus_err = 0; fifo_empty = 0; wdog_flag = 0; tf_req = 0;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk("reset word", reg_rdata, 32'h0);
    chk("reset pulses", {eng_start, eng_abort, tf_abort, tf_pass}, 4'b0);

    // R9 live status bits
    fifo_empty = 1; wdog_flag = 1; #1;
    chk("R9 live fifo/wdog", reg_rdata[20:19], 2'b11);
    wdog_flag = 0; step();

    // R11 pass when disabled
    tf_req = 1; step(); tf_req = 0;
    chk("R11 pass while disabled", {tf_abort, tf_pass}, 2'b01);

    // R10, R3, R7 random phase with enable low
    for (int i = 0; i < 60; i++) begin
      logic [31:0] w;
      logic irq;
      w = $urandom(); w[0] = 1'b0; w[17] = 1'b0;
      irq = 1'($urandom());
      fifo_empty = 1'($urandom());
      dev_irq = irq;
      wr_reg(w);
      chk("R10 R3 R7 idle word", reg_rdata, model_idle(w, irq, fifo_empty, 1'b0));
    end
    dev_irq = 0; fifo_empty = 0; step();
    chk("R7 mirror follows low", reg_rdata[18], 1'b0);

    // R1 start, direction read (dir=0)
    wr_reg(32'h0000_0001);
    chk("R1 start pulse", eng_start, 1'b1);
    chk("R1 active set", reg_rdata[16], 1'b1);
    step();
    chk("R1 start single", eng_start, 1'b0);

    // R11 refused while enabled
    tf_req = 1; step(); tf_req = 0;
    chk("R11 abort while enabled", {tf_abort, tf_pass}, 2'b10);

    // R5 error set during transfer, write 0 keeps
    bus_err = 1; step(); bus_err = 0;
    chk("R5 error set", reg_rdata[17], 1'b1);
    wr_reg(32'h0000_0001);
    chk("R5 write 0 keeps", reg_rdata[17], 1'b1);
    // R6 set and clear together
    bus_err = 1; wr_reg(32'h0002_0001); bus_err = 0;
    chk("R6 error set wins", reg_rdata[17], 1'b1);
    wr_reg(32'h0002_0001);
    chk("R5 W1C clears", reg_rdata[17], 1'b0);

    // R8 sticky completion, read direction
    dev_irq = 1; step(); dev_irq = 0; step();
    chk("R8 sticky completion", reg_rdata[18], 1'b1);
    dev_irq = 1; wr_reg(32'h0004_0001); dev_irq = 0;
    chk("R6 completion set wins", reg_rdata[18], 1'b1);
    wr_reg(32'h0004_0001);
    chk("R8 W1C clears", reg_rdata[18], 1'b0);

    // R4 done clears active
    eng_done = 1; step(); eng_done = 0;
    chk("R4 done clears active", reg_rdata[16], 1'b0);
    chk("R4 enable kept", reg_rdata[0], 1'b1);

    // R2 abort: disable, restart with done colliding, then clear enable
    wr_reg(32'h0000_0000);
    chk("R2 no abort when idle", eng_abort, 1'b0);
    eng_done = 1; wr_reg(32'h0000_0009); eng_done = 0;
    chk("R1 start beats done", {eng_start, reg_rdata[16]}, 2'b11);
    // R8 write direction: irq while active and fifo busy does not set
    dev_irq = 1; step();
    chk("R8 no set mid-write", reg_rdata[18], 1'b0);
    wr_reg(32'h0000_0008);
    dev_irq = 0;
    chk("R2 abort pulse", eng_abort, 1'b1);
    chk("R2 active cleared", reg_rdata[16], 1'b0);
    step();
    chk("R2 abort single", eng_abort, 1'b0);

    // R8 write direction completes once fifo empty and idle
    wr_reg(32'h0000_0009);
    eng_done = 1; step(); eng_done = 0;
    fifo_empty = 1; dev_irq = 1; step(); dev_irq = 0; step();
    chk("R8 write done latches", reg_rdata[18], 1'b1);
    chk("R9 fifo bit", reg_rdata[19], 1'b1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule